// File: doc/BRIEF.md
# Audio Codec Transfer Control Unit

This block decides how sample data moves between a stereo audio converter and its host. A configuration byte sets playback and capture separately to DMA or to programmed I/O. The block raises a DMA request for each direction when the converter asks for a sample, and drops the request when the host acknowledges it. A single-channel option carries all DMA traffic on the playback request line. When only one direction is enabled in that option, that direction uses the playback line. When both are enabled, only playback runs.

A one-cycle calibration request pulse is issued in three cases: after reset, when the power-down pin returns high, and when the mode-change gate closes while autocalibration is on. A down-counter counts per-sample strobes and raises a sticky interrupt at each terminal count. A rate-change write starts an init-busy window, unless that window has been disabled. Control, status and strobe pins are plain levels and single-cycle pulses. The register port has no back-pressure: a write completes in the cycle it is presented, and read data is a combinational function of the index.

Top module: `acx_xfer_ctl`

## Requirements
- R1: After reset these read values hold: index 9 reads 0x08, index 10 reads 0x00, index 11 reads 0x00 and index 12 reads 0x00. Both request outputs are low and the interrupt is low.
- R2: Index 9 holds these bits: bit0 playback enable, bit1 capture enable, bit2 single-channel mode, bit3 autocalibrate, bit6 playback PIO and bit7 capture PIO. Bits 4 and 5 always read 0. Bits 0 and 1 take any write. Bits 2, 3, 6 and 7 change only while the mode-change gate (index 12 bit0) is 1.
- R3: While playback is enabled with playback PIO at 0, a sample strobe raises `pb_drq` on the next cycle. An acknowledge on `pb_dack` drops it on the next cycle. A strobe and an acknowledge in the same cycle leave `pb_drq` high.
- R4: Capture enable and capture PIO act in the same way on `cp_drq` and `cp_dack`.
- R5: While single-channel mode is set, `cp_drq` stays low. Capture requests appear on `pb_drq` and are acknowledged on `pb_dack`. With both enables set, only playback requests are made.
- R6: While a direction's PIO bit is 1, its enable drives `pb_pio_en` or `cp_pio_en` high, and no DMA request is made for that direction.
- R7: When index 12 bit0 goes from 1 to 0 with autocalibrate at 1, `cal_req` pulses high for exactly one cycle, on the cycle after the gate reads 0. With autocalibrate at 0, no pulse is issued.
- R8: `cal_req` pulses once on the first cycle after reset is released, and once after each low-to-high change of `pdn_n`. Neither pulse depends on the autocalibrate bit.
- R9: The base count is {index 14, index 15}. A write to index 15 loads the counter. Each strobe made while either enable is set decrements the counter. The strobe that finds the counter at zero sets status bit0 (index 11 bit0) and reloads the counter, so the flag sets once every base+1 strobes. `irq` equals the status flag ANDed with interrupt enable (index 10 bit1).
- R10: The status flag stays set until any write to index 11. When a terminal strobe and that clear write fall in the same cycle, the flag stays set.
- R11: A write to index 8 (rate, bits 3:0) made with the gate at 1 and a value different from the current rate raises `init_busy` and status bit1 for INIT_CYCLES cycles. This does not happen if init-disable (index 10 bit3) is 1. A rate write made with the gate at 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pdn_n | input | 1 | Power-down pin, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index for write and read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| sample_stb | input | 1 | One pulse per converter sample |
| pb_dack | input | 1 | Playback DMA acknowledge |
| cp_dack | input | 1 | Capture DMA acknowledge |
| pb_drq | output | 1 | Playback (or shared) DMA request |
| cp_drq | output | 1 | Capture DMA request |
| pb_pio_en | output | 1 | Playback PIO data register active |
| cp_pio_en | output | 1 | Capture PIO data register active |
| cal_req | output | 1 | One-cycle calibration request |
| irq | output | 1 | Sample-count interrupt |
| init_busy | output | 1 | Init window after rate change |

## Verification
Two pairs of functions can collide in one cycle, and both collisions are provoked directly. A terminal-count strobe and the status-clear write are presented in the same clock, with the base count at zero so that every strobe is terminal. The flag must read 1 afterwards, and a later lone clear must drop it. In the same way, a sample strobe and a DMA acknowledge are driven together, and the request must stay high until a lone acknowledge removes it.

// File: rtl/acx_pkg.sv
package acx_pkg;
  localparam int IDX_W  = 4;
  localparam int BYTE_W = 8;
  localparam int BASE_W = 2 * BYTE_W;
  localparam int RATE_W = 4;

  localparam logic [IDX_W-1:0] IX_RATE = 4'd8;
  localparam logic [IDX_W-1:0] IX_CFG  = 4'd9;
  localparam logic [IDX_W-1:0] IX_PIN  = 4'd10;
  localparam logic [IDX_W-1:0] IX_STAT = 4'd11;
  localparam logic [IDX_W-1:0] IX_GATE = 4'd12;
  localparam logic [IDX_W-1:0] IX_BHI  = 4'd14;
  localparam logic [IDX_W-1:0] IX_BLO  = 4'd15;

  typedef struct packed {
    logic cpio;
    logic ppio;
    logic acal;
    logic sdc;
    logic cen;
    logic pen;
  } cfg_t;

  localparam cfg_t CFG_RST = '{cpio: 1'b0, ppio: 1'b0, acal: 1'b1,
                               sdc: 1'b0, cen: 1'b0, pen: 1'b0};
endpackage

// File: rtl/acx_regs.sv
module acx_regs
  import acx_pkg::*;
#(
  parameter int INIT_CYCLES = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [IDX_W-1:0]  addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              flag,
  output logic [BYTE_W-1:0] rdata,
  output cfg_t              cfg,
  output logic              ien,
  output logic              mce,
  output logic              base_load,
  output logic [BASE_W-1:0] load_val,
  output logic              stat_clr,
  output logic              init_busy
);
  localparam int IC_W = $clog2(INIT_CYCLES + 1);

  logic              initd;
  logic [RATE_W-1:0] rate;
  logic [BYTE_W-1:0] base_hi, base_lo;
  logic [IC_W-1:0]   init_cnt;
  logic              rate_chg;

  assign rate_chg  = wr && addr == IX_RATE && mce && wdata[RATE_W-1:0] != rate;
  assign base_load = wr && addr == IX_BLO;
  assign load_val  = {base_hi, wdata};
  assign stat_clr  = wr && addr == IX_STAT;
  assign init_busy = init_cnt != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg     <= CFG_RST;
      ien     <= 1'b0;
      initd   <= 1'b0;
      mce     <= 1'b0;
      base_hi <= '0;
      base_lo <= '0;
    end else if (wr) begin
      case (addr)
        IX_CFG: begin
          cfg.pen <= wdata[0];
          cfg.cen <= wdata[1];
          if (mce) begin
            cfg.sdc  <= wdata[2];
            cfg.acal <= wdata[3];
            cfg.ppio <= wdata[6];
            cfg.cpio <= wdata[7];
          end
        end
        IX_PIN: begin
          ien   <= wdata[1];
          initd <= wdata[3];
        end
        IX_GATE: mce     <= wdata[0];
        IX_BHI:  base_hi <= wdata;
        IX_BLO:  base_lo <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate     <= '0;
      init_cnt <= '0;
    end else if (rate_chg) begin
      rate <= wdata[RATE_W-1:0];
      if (!initd) init_cnt <= IC_W'(INIT_CYCLES);
    end else if (init_busy) begin
      init_cnt <= init_cnt - 1'b1;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      IX_RATE: rdata[RATE_W-1:0] = rate;
      IX_CFG:  rdata = {cfg.cpio, cfg.ppio, 2'b00, cfg.acal, cfg.sdc, cfg.cen, cfg.pen};
      IX_PIN:  rdata = {4'b0000, initd, 1'b0, ien, 1'b0};
      IX_STAT: rdata = {6'b0, init_busy, flag};
      IX_GATE: rdata = {7'b0, mce};
      IX_BHI:  rdata = base_hi;
      IX_BLO:  rdata = base_lo;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/acx_dma.sv
module acx_dma (
  input  logic clk,
  input  logic rst_n,
  input  logic pen,
  input  logic cen,
  input  logic ppio,
  input  logic cpio,
  input  logic sdc,
  input  logic sample_stb,
  input  logic pb_dack,
  input  logic cp_dack,
  output logic pb_drq,
  output logic cp_drq,
  output logic pb_pio_en,
  output logic cp_pio_en
);
  localparam int NCH = 2;

  logic [NCH-1:0] act, ack, pend;

  assign act[0] = pen && !ppio;
  assign act[1] = cen && !cpio && !(sdc && act[0]);
  assign ack[0] = pb_dack;
  assign ack[1] = sdc ? pb_dack : cp_dack;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pend[ch] <= 1'b0;
      else if (!act[ch])   pend[ch] <= 1'b0;
      else if (sample_stb) pend[ch] <= 1'b1;
      else if (ack[ch])    pend[ch] <= 1'b0;
    end
  end

  assign pb_drq    = pend[0] || (sdc && pend[1]);
  assign cp_drq    = !sdc && pend[1];
  assign pb_pio_en = pen && ppio;
  assign cp_pio_en = cen && cpio;
endmodule

// File: rtl/acx_cnt.sv
module acx_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stb,
  input  logic         en,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         clr,
  output logic         flag
);
  logic [W-1:0] cnt, base;
  logic         term;

  assign term = stb && en && cnt == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      base <= '0;
    end else if (load) begin
      cnt  <= load_val;
      base <= load_val;
    end else if (stb && en) begin
      cnt <= term ? base : cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    flag <= 1'b0;
    else if (term) flag <= 1'b1;
    else if (clr)  flag <= 1'b0;
  end
endmodule

// File: rtl/acx_cal.sv
module acx_cal (
  input  logic clk,
  input  logic rst_n,
  input  logic mce,
  input  logic acal,
  input  logic pdn_n,
  output logic cal_req
);
  logic booted, mce_q, pdn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      booted  <= 1'b0;
      mce_q   <= 1'b0;
      pdn_q   <= 1'b1;
      cal_req <= 1'b0;
    end else begin
      booted  <= 1'b1;
      mce_q   <= mce;
      pdn_q   <= pdn_n;
      cal_req <= !booted || (pdn_n && !pdn_q) || (acal && mce_q && !mce);
    end
  end
endmodule

// File: rtl/acx_xfer_ctl.sv
module acx_xfer_ctl
  import acx_pkg::*;
#(
  parameter int INIT_CYCLES = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pdn_n,
  input  logic              reg_wr,
  input  logic [IDX_W-1:0]  reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              sample_stb,
  input  logic              pb_dack,
  input  logic              cp_dack,
  output logic              pb_drq,
  output logic              cp_drq,
  output logic              pb_pio_en,
  output logic              cp_pio_en,
  output logic              cal_req,
  output logic              irq,
  output logic              init_busy
);
  cfg_t              cfg;
  logic              ien, mce, base_load, stat_clr, flag;
  logic [BASE_W-1:0] load_val;

  acx_regs #(.INIT_CYCLES(INIT_CYCLES)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .flag(flag), .rdata(reg_rdata), .cfg(cfg), .ien(ien), .mce(mce),
    .base_load(base_load), .load_val(load_val), .stat_clr(stat_clr),
    .init_busy(init_busy)
  );

  acx_dma u_dma (
    .clk(clk), .rst_n(rst_n), .pen(cfg.pen), .cen(cfg.cen), .ppio(cfg.ppio),
    .cpio(cfg.cpio), .sdc(cfg.sdc), .sample_stb(sample_stb), .pb_dack(pb_dack),
    .cp_dack(cp_dack), .pb_drq(pb_drq), .cp_drq(cp_drq),
    .pb_pio_en(pb_pio_en), .cp_pio_en(cp_pio_en)
  );

  acx_cnt #(.W(BASE_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .stb(sample_stb), .en(cfg.pen || cfg.cen),
    .load(base_load), .load_val(load_val), .clr(stat_clr), .flag(flag)
  );

  acx_cal u_cal (
    .clk(clk), .rst_n(rst_n), .mce(mce), .acal(cfg.acal), .pdn_n(pdn_n),
    .cal_req(cal_req)
  );

  assign irq = flag && ien;
endmodule

// File: rtl/acx_xfer_ctl_chk.sv
module acx_xfer_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic sdc,
  input logic ppio,
  input logic acal,
  input logic mce,
  input logic ien,
  input logic sample_stb,
  input logic pb_dack,
  input logic pb_drq,
  input logic cp_drq,
  input logic cal_req,
  input logic irq
);
  // R5: capture line silent in single-channel mode
  a_r5_sdc_cap_low: assert property (@(posedge clk) disable iff (!rst_n)
    sdc |-> !cp_drq);

  // R3: acknowledge without a new strobe drops the request
  a_r3_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
    pb_drq && pb_dack && !sample_stb |=> !pb_drq);

  // R6: playback PIO makes no playback DMA request
  a_r6_pio_no_drq: assert property (@(posedge clk) disable iff (!rst_n)
    ppio && $past(ppio) && !sdc && !$past(sdc) |-> !pb_drq);

  // R7: gate release with autocalibrate on gives a pulse
  a_r7_cal_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mce) && acal |=> cal_req);

  // R9: interrupt never high while disabled
  a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ien);
endmodule

bind acx_xfer_ctl acx_xfer_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sdc(cfg.sdc), .ppio(cfg.ppio), .acal(cfg.acal),
  .mce(mce), .ien(ien), .sample_stb(sample_stb), .pb_dack(pb_dack),
  .pb_drq(pb_drq), .cp_drq(cp_drq), .cal_req(cal_req), .irq(irq)
);

// File: tb/acx_xfer_ctl_test.sv
module acx_xfer_ctl_test;
  localparam int IC = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0, pdn_n = 1'b1;
  logic       reg_wr = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       sample_stb = 1'b0, pb_dack = 1'b0, cp_dack = 1'b0;
  logic       pb_drq, cp_drq, pb_pio_en, cp_pio_en, cal_req, irq, init_busy;

  int n_chk = 0, n_bad = 0, cal_cnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  acx_xfer_ctl #(.INIT_CYCLES(IC)) uut (
    .clk(clk), .rst_n(rst_n), .pdn_n(pdn_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sample_stb(sample_stb),
    .pb_dack(pb_dack), .cp_dack(cp_dack), .pb_drq(pb_drq), .cp_drq(cp_drq),
    .pb_pio_en(pb_pio_en), .cp_pio_en(cp_pio_en), .cal_req(cal_req), .irq(irq),
    .init_busy(init_busy)
  );

  always @(negedge clk) if (rst_n && cal_req) cal_cnt++;

  task automatic check(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic set_cfg(logic [7:0] d);
    wr(4'd12, 8'h01); wr(4'd9, d); wr(4'd12, 8'h00);
  endtask

  task automatic pulse(input bit s, input bit pa, input bit ca);
    @(negedge clk);
    sample_stb = s; pb_dack = pa; cp_dack = ca;
    @(negedge clk);
    sample_stb = 0; pb_dack = 0; cp_dack = 0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R8 boot pulse", cal_cnt, 1);
    rd(4'd9, d);  check("R1 cfg", d, 8'h08);
    rd(4'd10, d); check("R1 pin", d, 8'h00);
    rd(4'd11, d); check("R1 stat", d, 8'h00);
    rd(4'd12, d); check("R1 gate", d, 8'h00);
    check("R1 drq", {pb_drq, cp_drq, irq}, 0);
  endtask

  task automatic t_regs;
    logic [7:0] d;
    wr(4'd9, 8'hC7); rd(4'd9, d); check("R2 gate closed", d, 8'h0B);
    set_cfg(8'hF7);  rd(4'd9, d); check("R2 gate open", d, 8'hC7);
    set_cfg(8'h08);  rd(4'd9, d); check("R2 restore", d, 8'h08);
  endtask

  task automatic t_playback;
    wr(4'd9, 8'h09);
    pulse(1, 0, 0); check("R3 raise", pb_drq, 1);
    pulse(1, 1, 0); check("R3 stb+ack", pb_drq, 1);
    pulse(0, 1, 0); check("R3 drop", pb_drq, 0);
    check("R3 no pio", pb_pio_en, 0);
  endtask

  task automatic t_capture;
    wr(4'd9, 8'h0A);
    pulse(1, 0, 0); check("R4 raise", cp_drq, 1);
    check("R4 pb idle", pb_drq, 0);
    pulse(0, 1, 0); check("R4 wrong ack", cp_drq, 1);
    pulse(0, 0, 1); check("R4 drop", cp_drq, 0);
  endtask

  task automatic t_pio;
    set_cfg(8'h49);
    check("R6 pb pio", pb_pio_en, 1);
    pulse(1, 0, 0); check("R6 pb no drq", pb_drq, 0);
    set_cfg(8'h8A);
    check("R6 cp pio", cp_pio_en, 1);
    pulse(1, 0, 0); check("R6 cp no drq", cp_drq, 0);
  endtask

  task automatic t_single;
    set_cfg(8'h0E);
    pulse(1, 0, 0);
    check("R5 cap on pb", pb_drq, 1); check("R5 cp low", cp_drq, 0);
    pulse(0, 0, 1); check("R5 cp ack ignored", pb_drq, 1);
    pulse(0, 1, 0); check("R5 pb ack", pb_drq, 0);
    wr(4'd9, 8'h0F);
    pulse(1, 0, 0); check("R5 both cp low", cp_drq, 0);
    pulse(0, 1, 0); check("R5 both one ack", pb_drq, 0);
    set_cfg(8'h08);
  endtask

  task automatic t_cal;
    int c0;
    set_cfg(8'h00);
    repeat (3) @(negedge clk);
    c0 = cal_cnt;
    wr(4'd12, 8'h01); wr(4'd12, 8'h00); repeat (3) @(negedge clk);
    check("R7 acal off", cal_cnt - c0, 0);
    set_cfg(8'h08);
    repeat (3) @(negedge clk);
    c0 = cal_cnt;
    wr(4'd12, 8'h01); wr(4'd12, 8'h00); repeat (3) @(negedge clk);
    check("R7 acal on", cal_cnt - c0, 1);
    set_cfg(8'h00);
    repeat (3) @(negedge clk);
    c0 = cal_cnt;
    pdn_n = 1'b0; repeat (3) @(negedge clk);
    pdn_n = 1'b1; repeat (3) @(negedge clk);
    check("R8 pdn rise", cal_cnt - c0, 1);
    set_cfg(8'h08);
  endtask

  task automatic t_count;
    logic [7:0] d;
    wr(4'd9, 8'h09); wr(4'd14, 8'h00); wr(4'd15, 8'h02);
    wr(4'd11, 8'h00); wr(4'd10, 8'h02);
    pulse(1, 0, 0); pulse(1, 0, 0);
    check("R9 before tc", irq, 0);
    pulse(1, 0, 0);
    check("R9 tc irq", irq, 1);
    rd(4'd11, d); check("R9 stat bit0", d[0], 1);
    pulse(1, 0, 0); check("R10 sticky", irq, 1);
    wr(4'd11, 8'h00); check("R10 cleared", irq, 0);
    pulse(1, 0, 0); pulse(1, 0, 0);
    check("R9 reload tc", irq, 1);
    wr(4'd10, 8'h00); check("R9 gated", irq, 0);
    rd(4'd11, d); check("R9 flag kept", d[0], 1);
  endtask

  task automatic t_collide;
    logic [7:0] d;
    wr(4'd15, 8'h00); wr(4'd11, 8'h00);
    @(negedge clk);
    sample_stb = 1; reg_addr = 4'd11; reg_wdata = 0; reg_wr = 1;
    @(negedge clk);
    sample_stb = 0; reg_wr = 0;
    rd(4'd11, d); check("R10 set wins", d[0], 1);
    wr(4'd11, 8'h00);
    rd(4'd11, d); check("R10 lone clear", d[0], 0);
  endtask

  task automatic t_init;
    logic [7:0] d;
    wr(4'd12, 8'h01); wr(4'd8, 8'h05);
    check("R11 busy", init_busy, 1);
    rd(4'd11, d); check("R11 stat bit1", d[1], 1);
    repeat (IC - 2) @(negedge clk); check("R11 still busy", init_busy, 1);
    repeat (4) @(negedge clk);     check("R11 ended", init_busy, 0);
    wr(4'd8, 8'h05); check("R11 same rate", init_busy, 0);
    wr(4'd10, 8'h08); wr(4'd8, 8'h06); check("R11 disabled", init_busy, 0);
    rd(4'd8, d); check("R11 rate taken", d, 8'h06);
    wr(4'd10, 8'h00); wr(4'd12, 8'h00); wr(4'd8, 8'h07);
    check("R11 gate closed", init_busy, 0);
    rd(4'd8, d); check("R11 rate ignored", d, 8'h06);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset; t_regs; t_playback; t_capture; t_pio; t_single;
    t_cal; t_count; t_collide; t_init;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule